// File: doc/BRIEF.md
# Programmable Timer Channel

A single general-purpose counter channel with a small register port. Software writes a control word and a reload word, then reads back the control word, the reload word and the live count. The channel counts up or down at 16 or 32 bits. It advances on one of three kinds of source: a strobe from an internal prescaler, the synchronized rising edges of an external event pin, or a terminal-count strobe from a lower channel in a chain. An external level can also gate the counting.

When a counting step finds the count already at its terminal value, that step is a terminal event. The event either reloads the counter or parks it there. It also sets a sticky status bit, and that bit drives an interrupt line when the interrupt is enabled. A debug-halt pin can freeze the count if the control word asks for it.

The sequencing is a three-state machine. ST_IDLE means stopped. In ST_RUN the channel counts. ST_DONE means parked after a terminal event with reload off. The transitions are:
- **arm**: IDLE to RUN, when control is written with enable set. This loads the count.
- **park**: RUN to DONE, on a terminal event with reload off.
- **stop**: RUN to IDLE, or DONE to IDLE, when control is written with enable clear.

A write with enable set in RUN or DONE keeps the state it finds and does not load the count.

Top module: `gp_timer_chan`

## Requirements
- R1: After reset the control readback, reload readback, count, status, irq and tc_out are all zero.
- R2: A control write (reg_sel=0) with bit 15 set taken in ST_IDLE loads the count. The value is zero when bit 2 (down) and bit 0 (reload) are both 0; otherwise it is the reload word masked to the width. A control write with bit 15 clear stops the channel, and the count holds.
- R3: Control bits 8:6 hold a code k. For k from 0 to 6 the channel takes one step every 2^k clock cycles. For k=7 it takes one step per synchronized rising edge of ext_evt; a steady high level counts once.
- R4: Bit 2 chooses up (0) or down (1). The terminal value is all-ones at the width when counting up and zero when counting down. With reload on, a reload value R gives one tc_out pulse every R+1 steps going down, and every (all-ones minus R)+1 steps going up.
- R5: Bit 1 chooses 32 bits (1) or 16 bits (0). In 16-bit mode count bits 31:16 read zero, and the loaded value is masked.
- R6: Bit 0 set makes a terminal event reload the count from the reload word. Bit 0 clear parks the count at the terminal value with no further tc_out until the channel is stopped and re-armed. A write with bit 15 set while parked does not restart it.
- R7: Each terminal event raises tc_out for exactly one cycle and sets the sticky status bit. A control write with bit 9 set clears status. A set in the same cycle wins. Bit 9 always reads back 0.
- R8: irq is high exactly when status is set and control bit 3 is 1.
- R9: Bits 5:4 = 1 step only while the synchronized ext_gate is low, and = 2 step only while it is high.
- R10: Bits 5:4 = 3 take one step per cycle in which chain_in is high, whatever bits 8:6 hold.
- R11: With bit 10 set and dbg_halt high, the count does not change. With bit 10 clear, dbg_halt has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Write target: 0 control, 1 reload |
| reg_wdata | input | 32 | Write data |
| dbg_halt | input | 1 | CPU debug-halt indication |
| ext_evt | input | 1 | External event / clock pin (asynchronous) |
| ext_gate | input | 1 | External gate level (asynchronous) |
| chain_in | input | 1 | Terminal-count strobe of the lower channel |
| ctrl_rd | output | 16 | Control word readback |
| reload_rd | output | 32 | Reload word readback |
| count_rd | output | 32 | Live count |
| status | output | 1 | Sticky terminal-count status |
| irq | output | 1 | Interrupt request |
| tc_out | output | 1 | One-cycle terminal-count strobe |

## Verification
A wrong state or a wrong prescaler phase shows up as a tc_out interval that differs from (R+1)·2^k cycles. This is visible within one period after the first pulse. A machine stuck in ST_RUN after a terminal event with reload off gives a second tc_out, or a count that moves in the following cycles. A machine that fails to leave ST_IDLE gives a count frozen at the loaded value. Status faults reach irq in the same cycle, and gate, event and chain faults show as a count that is off after a fixed number of cycles.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
    typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RUN = 2'd1, ST_DONE = 2'd2} run_state_e;
    typedef enum logic [1:0] {MD_FREE = 2'd0, MD_GATE_LO = 2'd1, MD_GATE_HI = 2'd2, MD_CHAIN = 2'd3} gp_mode_e;

    localparam int B_EN    = 15;
    localparam int B_DBG   = 10;
    localparam int B_ICLR  = 9;
    localparam int SEL_LO  = 6;
    localparam int MODE_LO = 4;
    localparam int B_INTEN = 3;
    localparam int B_DOWN  = 2;
    localparam int B_WIDE  = 1;
    localparam int B_RLD   = 0;

    localparam logic [2:0]  SEL_EXT   = 3'd7;
    localparam logic [15:0] CTRL_KEEP = 16'h85FF;
endpackage

// File: rtl/gpt_tick_gen.sv
module gpt_tick_gen
    import gpt_pkg::*;
#(
    parameter int PRE_W = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [2:0] sel,
    input  gp_mode_e   mode,
    input  logic       ext_evt,
    input  logic       ext_gate,
    input  logic       chain_tc,
    output logic       tick
);
    logic [2:0]       evt_sync;
    logic [1:0]       gate_sync;
    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] pre_mask;
    logic             evt_rise;
    logic             pre_hit;
    logic             src_en;
    logic             gate_lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_sync  <= '0;
            gate_sync <= '0;
            pre_cnt   <= '0;
        end else begin
            evt_sync  <= {evt_sync[1:0], ext_evt};
            gate_sync <= {gate_sync[0], ext_gate};
            pre_cnt   <= run ? pre_cnt + 1'b1 : '0;
        end
    end

    always_comb begin
        pre_mask = '0;
        for (int i = 0; i < PRE_W; i++) begin
            if (i < int'(sel)) pre_mask[i] = 1'b1;
        end
    end

    assign evt_rise = evt_sync[1] & ~evt_sync[2];
    assign pre_hit  = (pre_cnt & pre_mask) == pre_mask;
    assign src_en   = (sel == SEL_EXT) ? evt_rise : pre_hit;
    assign gate_lvl = gate_sync[1];

    always_comb begin
        unique case (mode)
            MD_FREE:    tick = src_en;
            MD_GATE_LO: tick = src_en & ~gate_lvl;
            MD_GATE_HI: tick = src_en & gate_lvl;
            MD_CHAIN:   tick = chain_tc;
            default:    tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/gpt_core.sv
module gpt_core
    import gpt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic             new_en,
    input  logic             new_down,
    input  logic             new_rld,
    input  logic             new_wide,
    input  logic             new_iclr,
    input  logic             cur_dbg,
    input  logic             cur_down,
    input  logic             cur_rld,
    input  logic             cur_wide,
    input  logic [CNT_W-1:0] reload,
    input  logic             tick,
    input  logic             dbg_halt,
    output logic [CNT_W-1:0] count,
    output logic             tc_pulse,
    output logic             status,
    output logic             running
);
    localparam int HALF = CNT_W / 2;
    localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);
    localparam logic [CNT_W-1:0] M_WIDE = '1;
    localparam logic [CNT_W-1:0] M_NARR = {{(CNT_W-HALF){1'b0}}, {HALF{1'b1}}};

    run_state_e       state, state_nx;
    logic [CNT_W-1:0] cur_mask, new_mask, load_val;
    logic             frozen, step, term, hit, load;

    assign cur_mask = cur_wide ? M_WIDE : M_NARR;
    assign new_mask = new_wide ? M_WIDE : M_NARR;
    assign frozen   = cur_dbg & dbg_halt;
    assign step     = (state == ST_RUN) & tick & ~frozen & ~ctrl_wr;
    assign term     = cur_down ? (count == '0) : (count == cur_mask);
    assign hit      = step & term;
    assign load     = ctrl_wr & new_en & (state == ST_IDLE);
    assign load_val = (!new_down && !new_rld) ? '0 : (reload & new_mask);
    assign running  = (state == ST_RUN);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (ctrl_wr && new_en) state_nx = ST_RUN;          // arm
            ST_RUN: begin
                if (ctrl_wr && !new_en)      state_nx = ST_IDLE;         // stop
                else if (hit && !cur_rld)    state_nx = ST_DONE;         // park
            end
            ST_DONE: if (ctrl_wr && !new_en) state_nx = ST_IDLE;         // stop
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count    <= '0;
            tc_pulse <= 1'b0;
            status   <= 1'b0;
        end else begin
            if (load)                count <= load_val;
            else if (ctrl_wr)        count <= count & new_mask;
            else if (hit && cur_rld) count <= reload & cur_mask;
            else if (step && !term)  count <= (cur_down ? count - ONE : count + ONE) & cur_mask;
            tc_pulse <= hit;
            if (hit)                        status <= 1'b1;
            else if (ctrl_wr && new_iclr)   status <= 1'b0;
        end
    end
endmodule

// File: rtl/gp_timer_chan.sv
module gp_timer_chan
    import gpt_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PRE_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [CNT_W-1:0] reg_wdata,
    input  logic             dbg_halt,
    input  logic             ext_evt,
    input  logic             ext_gate,
    input  logic             chain_in,
    output logic [15:0]      ctrl_rd,
    output logic [CNT_W-1:0] reload_rd,
    output logic [CNT_W-1:0] count_rd,
    output logic             status,
    output logic             irq,
    output logic             tc_out
);
    logic [15:0]      ctrl_q;
    logic [CNT_W-1:0] reload_q;
    logic             ctrl_wr, running, tick;

    assign ctrl_wr = reg_wr & ~reg_sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            reload_q <= '0;
        end else if (reg_wr) begin
            if (reg_sel) reload_q <= reg_wdata;
            else         ctrl_q   <= reg_wdata[15:0] & CTRL_KEEP;
        end
    end

    gpt_tick_gen #(.PRE_W(PRE_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (running),
        .sel      (ctrl_q[SEL_LO+2:SEL_LO]),
        .mode     (gp_mode_e'(ctrl_q[MODE_LO+1:MODE_LO])),
        .ext_evt  (ext_evt),
        .ext_gate (ext_gate),
        .chain_tc (chain_in),
        .tick     (tick)
    );

    gpt_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_wr  (ctrl_wr),
        .new_en   (reg_wdata[B_EN]),
        .new_down (reg_wdata[B_DOWN]),
        .new_rld  (reg_wdata[B_RLD]),
        .new_wide (reg_wdata[B_WIDE]),
        .new_iclr (reg_wdata[B_ICLR]),
        .cur_dbg  (ctrl_q[B_DBG]),
        .cur_down (ctrl_q[B_DOWN]),
        .cur_rld  (ctrl_q[B_RLD]),
        .cur_wide (ctrl_q[B_WIDE]),
        .reload   (reload_q),
        .tick     (tick),
        .dbg_halt (dbg_halt),
        .count    (count_rd),
        .tc_pulse (tc_out),
        .status   (status),
        .running  (running)
    );

    assign ctrl_rd   = ctrl_q;
    assign reload_rd = reload_q;
    assign irq       = status & ctrl_q[B_INTEN];
endmodule

// File: rtl/gpt_chan_chk.sv
module gpt_chan_chk
    import gpt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic             reg_sel,
    input logic [CNT_W-1:0] reg_wdata,
    input logic             dbg_halt,
    input logic [15:0]      ctrl_rd,
    input logic [CNT_W-1:0] count_rd,
    input logic             status,
    input logic             tc_out
);
    logic ctrl_wr;
    assign ctrl_wr = reg_wr && !reg_sel;

    // R7
    status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status && !(ctrl_wr && reg_wdata[B_ICLR])) |=> status);

    // R7
    tc_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tc_out |-> status);

    // R5
    narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_rd[B_WIDE] |-> (count_rd[CNT_W-1:CNT_W/2] == '0));

    // R2
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_rd[B_EN] && !ctrl_wr) |=> $stable(count_rd));

    // R11
    debug_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd[B_DBG] && dbg_halt && !ctrl_wr) |=> $stable(count_rd));

    // R6
    park_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_out && !ctrl_rd[B_RLD] && !ctrl_wr) |=> (!tc_out && $stable(count_rd)));
endmodule

bind gp_timer_chan gpt_chan_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .dbg_halt  (dbg_halt),
    .ctrl_rd   (ctrl_rd),
    .count_rd  (count_rd),
    .status    (status),
    .tc_out    (tc_out)
);

// File: tb/gp_timer_chan_test.sv
`timescale 1ns/1ps
module gp_timer_chan_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        dbg_halt = 1'b0, ext_evt = 1'b0, ext_gate = 1'b0, chain_in = 1'b0;
    logic [15:0] ctrl_rd;
    logic [31:0] reload_rd, count_rd;
    logic        status, irq, tc_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    gp_timer_chan uut (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(bit en, bit dbg, bit iclr, int sel, int mode,
                                        bit inten, bit down, bit wide, bit rld);
        logic [31:0] v = '0;
        v[15] = en; v[10] = dbg; v[9] = iclr;
        v[8:6] = 3'(sel); v[5:4] = 2'(mode);
        v[3] = inten; v[2] = down; v[1] = wide; v[0] = rld;
        return v;
    endfunction

    task automatic wr(bit sel, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_tc(output bit ok);
        ok = 0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (tc_out) begin ok = 1; break; end
        end
    endtask

    task automatic measure(output int p);
        bit ok;
        p = 0;
        wait_tc(ok);
        if (!ok) begin p = -1; return; end
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            p++;
            if (tc_out) return;
        end
        p = -1;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int p;
        bit ok;
        cycles(3);
        rst_n = 1'b1;
        cycles(2);
        // R1 reset state
        check("R1 ctrl", 32'(ctrl_rd), 0);
        check("R1 reload", reload_rd, 0);
        check("R1 count", count_rd, 0);
        check("R1 status/irq/tc", {29'd0, status, irq, tc_out}, 0);

        // R3 prescaler sweep, down with reload 3: period (3+1)<<k
        for (int k = 0; k < 7; k++) begin
            wr(0, mk(0,0,0,0,0,0,1,0,1));
            wr(1, 32'd3);
            wr(0, mk(1,0,0,k,0,0,1,0,1));
            if (k == 0) check("R2 load down", count_rd, 3);
            measure(p);
            check($sformatf("R3 R4 period sel=%0d", k), 32'(p), 32'(4 << k));
        end

        // R4 R6 up 16-bit with reload
        wr(0, mk(0,0,0,0,0,0,0,0,0));
        wr(1, 32'h0000_FFF0);
        wr(0, mk(1,0,0,0,0,0,0,0,1));
        check("R2 load up", count_rd, 32'hFFF0);
        measure(p);
        check("R4 up period 16b", 32'(p), 16);
        check("R6 reload value", count_rd, 32'hFFF0);

        // R4 R5 32-bit up
        wr(0, mk(0,0,0,0,0,0,0,1,1));
        wr(1, 32'hFFFF_FFF8);
        wr(0, mk(1,0,0,0,0,0,0,1,1));
        check("R5 load 32b", count_rd, 32'hFFFF_FFF8);
        measure(p);
        check("R4 up period 32b", 32'(p), 8);
        wr(0, mk(0,0,0,0,0,0,0,1,1));
        wr(0, mk(1,0,0,0,0,0,0,0,1));
        check("R5 masked load", count_rd, 32'h0000_FFF8);
        cycles(5);
        check("R5 upper zero", {16'd0, count_rd[31:16]}, 0);

        // R2 up with reload off loads zero
        wr(0, mk(0,0,0,0,0,0,0,0,0));
        wr(0, mk(1,0,0,0,0,0,0,0,0));
        check("R2 zero load", count_rd, 0);
        cycles(4);
        check("R2 counting up", count_rd, 4);

        // R6 R7 R8 down, no reload, interrupt enabled
        wr(0, mk(0,0,1,0,0,1,1,0,0));
        check("R7 cleared", 32'(status), 0);
        check("R7 clear bit reads 0", 32'(ctrl_rd[9]), 0);
        wr(1, 32'd4);
        wr(0, mk(1,0,0,0,0,1,1,0,0));
        wait_tc(ok);
        check("R6 terminal seen", 32'(ok), 1);
        check("R6 parked at zero", count_rd, 0);
        check("R7 R8 status irq", {30'd0, status, irq}, 3);
        p = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (tc_out) p++;
        end
        check("R6 no further tc", 32'(p), 0);
        check("R6 still zero", count_rd, 0);
        wr(0, mk(1,0,1,0,0,1,1,0,0));
        check("R7 R8 clear", {30'd0, status, irq}, 0);
        cycles(5);
        check("R6 no restart while parked", count_rd, 0);

        // R8 interrupt disabled
        wr(0, mk(0,0,0,0,0,0,1,0,1));
        wr(1, 32'd2);
        wr(0, mk(1,0,0,0,0,0,1,0,1));
        wait_tc(ok);
        check("R8 status set irq masked", {30'd0, status, irq}, 2);
        wr(0, mk(1,0,1,0,0,0,1,0,1));

        // R11 debug freeze
        wr(0, mk(0,0,0,0,0,0,1,0,1));
        wr(1, 32'd100);
        dbg_halt = 1'b1;
        wr(0, mk(1,1,0,0,0,0,1,0,1));
        cycles(10);
        check("R11 frozen", count_rd, 100);
        dbg_halt = 1'b0;
        cycles(10);
        check("R11 resumes", count_rd, 90);
        wr(0, mk(0,0,0,0,0,0,1,0,1));
        dbg_halt = 1'b1;
        wr(0, mk(1,0,0,0,0,0,1,0,1));
        cycles(10);
        check("R11 ignored when bit clear", count_rd, 90);
        dbg_halt = 1'b0;

        // R9 gated modes
        wr(0, mk(0,0,0,0,0,0,1,0,1));
        ext_gate = 1'b1;
        cycles(3);
        wr(0, mk(1,0,0,0,1,0,1,0,1));
        cycles(10);
        check("R9 low gate blocked", count_rd, 100);
        ext_gate = 1'b0;
        cycles(12);
        check("R9 low gate open", count_rd, 90);
        wr(0, mk(0,0,0,0,0,0,1,0,1));
        cycles(3);
        wr(0, mk(1,0,0,0,2,0,1,0,1));
        cycles(10);
        check("R9 high gate blocked", count_rd, 100);
        ext_gate = 1'b1;
        cycles(12);
        check("R9 high gate open", count_rd, 90);
        ext_gate = 1'b0;

        // R3 external event
        wr(0, mk(0,0,0,0,0,0,1,0,1));
        wr(1, 32'd50);
        wr(0, mk(1,0,0,7,0,0,1,0,1));
        for (int i = 0; i < 5; i++) begin
            ext_evt = 1'b1; cycles(3);
            ext_evt = 1'b0; cycles(3);
        end
        cycles(4);
        check("R3 event count", count_rd, 45);
        ext_evt = 1'b1;
        cycles(20);
        check("R3 level counts once", count_rd, 44);
        ext_evt = 1'b0;

        // R10 chain mode
        wr(0, mk(0,0,0,0,0,0,0,1,1));
        wr(1, 32'd10);
        wr(0, mk(1,0,0,0,3,0,0,1,1));
        cycles(10);
        check("R10 idle without chain", count_rd, 10);
        for (int i = 0; i < 7; i++) begin
            chain_in = 1'b1; cycles(1);
            chain_in = 1'b0; cycles(1);
        end
        cycles(2);
        check("R10 chain steps", count_rd, 17);

        // R2 stop holds
        wr(0, mk(0,0,0,0,0,0,0,1,1));
        chain_in = 1'b1;
        cycles(5);
        chain_in = 1'b0;
        check("R2 stop holds", count_rd, 17);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule